// File: doc/BRIEF.md
# ECC Sub-Word Read-Modify-Write Unit

This block sits between a bus-side request port and a single-port synchronous memory that keeps seven check bits beside every 32-bit word. Full-word writes are encoded and written in the cycle they are accepted. Byte and half-word writes, while protection is on, become a read-modify-write: the aligned word is read, single-bit errors in it are repaired, the new byte lanes are merged in, check bits are recomputed and the whole word is written back to the same address. A read that finds a double-bit error stops the write and raises a flag.

Reads are checked on the way back. A single-bit error is corrected and reported as correctable. A double-bit error is reported as uncorrectable. A separate scrub port lets software or a timer walk the array one word at a time. A scrub writes a word back only when that word holds a correctable error, so single errors are removed before a second flip in the same word makes it unrecoverable.

While a read, read-modify-write or scrub is in progress, the request port is not ready. No other access can reach the memory between the read and the write-back of a sequence.

Top module: `ecc_rmw_unit`

## Requirements
- R1: A write with `req_be`=4'b1111 is sent to memory in the cycle it is accepted, with no read. The data go out unchanged. Check bits c0..c5 are computed by placing data bit k at the k-th codeword position (counting from 1) that is not a power of two, so data bit 0 sits at position 3. Check bit ci is the XOR of the data bits whose position has bit i set. c6 is the XOR of all 32 data bits and c0..c5.
- R2: With `ecc_en`=1, a write with any other `req_be` value reads the addressed word in the accepting cycle. In the next cycle it writes the merged word to the same address, with all four byte enables set and freshly encoded check bits. Byte lane b is `data[8b+7:8b]`, taken from `req_wdata` where `req_be[b]`=1 and from the stored word elsewhere.
- R3: During a read-modify-write, a single-bit error in the stored word is corrected before the merge, and the response reports it as correctable.
- R4: During a read-modify-write, a double-bit error in the stored word causes no memory write, and the response reports it as uncorrectable.
- R5: A read returns the corrected word on `rsp_rdata`, with `rsp_valid` high on the second falling clock edge after the accepting rising edge. A full-word write responds on the first falling edge.
- R6: A single flipped check bit, including c6, is reported as correctable and does not alter the returned data.
- R7: A scrub reads the word. It writes back the corrected data and check bits only when a single-bit error was found, and reports that error. A clean word causes no write.
- R8: `req_ready` is low for exactly the one cycle after a read, read-modify-write or scrub is accepted. `scrub_ready` is low whenever `req_valid` is high, so bus requests win over scrubs.
- R9: With `ecc_en`=0, sub-word writes go straight to memory with their byte enables and no read. Reads return the raw stored data with no error flags. The memory model writes check bits only when all four byte enables are set.
- R10: Every accepted operation produces one `rsp_valid` pulse. `rsp_corr` and `rsp_uncorr` are never high together, and are never high without `rsp_valid`.
- R11: During and after reset, and before any request arrives, `req_ready`=1, `rsp_valid`=0 and `mem_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Enables checking, correction and read-modify-write |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Bus request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for the write |
| scrub_valid | input | 1 | Scrub request present |
| scrub_addr | input | ADDR_W | Word address to scrub |
| scrub_ready | output | 1 | Scrub request accepted this cycle when high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Corrected (or raw) read data |
| rsp_corr | output | 1 | Single-bit error corrected |
| rsp_uncorr | output | 1 | Double-bit error detected |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_wchk | output | 7 | Memory write check bits |
| mem_be | output | 4 | Memory byte enables |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |
| mem_rchk | input | 7 | Memory read check bits, one cycle after the read |

## Verification
The bench flips single data bits, single check bits (including c6) and pairs of data bits in the memory model. It then runs reads, sub-word writes and scrubs over those words, and predicts each result by comparing the stored codeword with its clean encoding. A design that merged before correcting would write a silently corrupted word back with valid check bits. A design that skipped the abort would overwrite a word with a double-bit error. A scrub that always wrote back would show up as extra memory writes on clean words. The bench also checks bus-over-scrub priority, the one-cycle busy window and the behaviour with protection off, where a read here would show up as an extra memory read and raw data would come back altered.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam int CHK_W  = HAM_W + 1;
    localparam int LANES  = DATA_W / 8;
    localparam int CW_MAX = DATA_W + HAM_W;

    typedef enum logic [1:0] {OP_READ, OP_RMW, OP_SCRUB} op_e;
    typedef enum logic       {ST_IDLE, ST_RD}             state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              corr;
        logic              uncorr;
    } dec_res_t;

    // codeword position (1-based) of data bit k: the k-th non power of two
    function automatic int data_pos(input int k);
        int n;
        int p;
        n = 0;
        p = 0;
        for (int q = 1; q < 64; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == k) p = q;
                n = n + 1;
            end
        end
        return p;
    endfunction

    function automatic logic [CHK_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        logic [5:0]       pos;
        c = '0;
        for (int k = 0; k < DATA_W; k++) begin
            pos = 6'(data_pos(k));
            for (int i = 0; i < HAM_W; i++) begin
                if (pos[i]) c[i] = c[i] ^ d[k];
            end
        end
        c[HAM_W] = (^d) ^ (^c[HAM_W-1:0]);
        return c;
    endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_rmw_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    output logic [CHK_W-1:0]  chk
);
    assign chk = secded_enc(din);
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_rmw_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic [CHK_W-1:0]  chk,
    output dec_res_t          res
);
    logic [CHK_W-1:0] recomputed;
    logic [HAM_W-1:0] syn;
    logic             odd;

    always_comb begin
        recomputed = secded_enc(din);
        syn        = recomputed[HAM_W-1:0] ^ chk[HAM_W-1:0];
        odd        = (^din) ^ (^chk);
        res.data   = din;
        res.corr   = 1'b0;
        res.uncorr = 1'b0;
        if (odd) begin
            if ((syn & (syn - 1'b1)) == '0) begin
                res.corr = 1'b1;              // a check bit flipped
            end else if (int'(syn) <= CW_MAX) begin
                res.corr = 1'b1;
                for (int k = 0; k < DATA_W; k++) begin
                    if (data_pos(k) == int'(syn)) res.data[k] = ~din[k];
                end
            end else begin
                res.uncorr = 1'b1;
            end
        end else if (syn != '0) begin
            res.uncorr = 1'b1;
        end
    end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import ecc_rmw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              scrub_valid,
    input  logic [ADDR_W-1:0] scrub_addr,
    output logic              scrub_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_corr,
    output logic              rsp_uncorr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_be,
    input  logic [DATA_W-1:0] mem_rdata,
    input  dec_res_t          dec,
    output logic [DATA_W-1:0] enc_data
);
    state_e            state, state_n;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              en_q;

    logic              idle, take_req, take_scr, direct_wr;
    logic [DATA_W-1:0] fixed, merged;

    assign idle        = (state == ST_IDLE);
    assign req_ready   = idle;
    assign scrub_ready = idle & ~req_valid;
    assign take_req    = idle & req_valid;
    assign take_scr    = idle & ~req_valid & scrub_valid;
    assign direct_wr   = take_req & req_write & ((&req_be) | ~ecc_en);

    assign fixed = en_q ? dec.data : mem_rdata;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : fixed[8*b +: 8];
    end

    always_comb begin
        state_n   = state;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_addr;
        mem_be    = req_be;
        enc_data  = req_wdata;
        case (state)
            ST_IDLE: begin
                if (take_req) begin
                    mem_en = 1'b1;
                    if (direct_wr) mem_we = 1'b1;
                    else           state_n = ST_RD;
                end else if (take_scr) begin
                    mem_en   = 1'b1;
                    mem_addr = scrub_addr;
                    state_n  = ST_RD;
                end
            end
            ST_RD: begin
                state_n  = ST_IDLE;
                mem_addr = addr_q;
                mem_be   = '1;
                enc_data = (op_q == OP_RMW) ? merged : fixed;
                if (op_q == OP_RMW && !dec.uncorr) begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                end
                if (op_q == OP_SCRUB && en_q && dec.corr) begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign mem_wdata = enc_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            op_q       <= OP_READ;
            addr_q     <= '0;
            wdata_q    <= '0;
            be_q       <= '0;
            en_q       <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_corr   <= 1'b0;
            rsp_uncorr <= 1'b0;
        end else begin
            state <= state_n;
            if (take_req && !direct_wr) begin
                op_q    <= req_write ? OP_RMW : OP_READ;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
                en_q    <= ecc_en;
            end else if (take_scr) begin
                op_q   <= OP_SCRUB;
                addr_q <= scrub_addr;
                en_q   <= ecc_en;
            end
            rsp_valid  <= direct_wr | (state == ST_RD);
            rsp_rdata  <= (state == ST_RD) ? fixed : '0;
            rsp_corr   <= (state == ST_RD) & en_q & dec.corr;
            rsp_uncorr <= (state == ST_RD) & en_q & dec.uncorr;
        end
    end
endmodule

// File: rtl/ecc_rmw_unit.sv
module ecc_rmw_unit
    import ecc_rmw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    input  logic              scrub_valid,
    input  logic [ADDR_W-1:0] scrub_addr,
    output logic              scrub_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_corr,
    output logic              rsp_uncorr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [6:0]        mem_wchk,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata,
    input  logic [6:0]        mem_rchk
);
    dec_res_t          dec;
    logic [DATA_W-1:0] enc_data;

    ecc_dec u_dec (
        .din (mem_rdata),
        .chk (mem_rchk),
        .res (dec)
    );

    ecc_enc u_enc (
        .din (enc_data),
        .chk (mem_wchk)
    );

    rmw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ecc_en      (ecc_en),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .scrub_valid (scrub_valid),
        .scrub_addr  (scrub_addr),
        .scrub_ready (scrub_ready),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_corr    (rsp_corr),
        .rsp_uncorr  (rsp_uncorr),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_be      (mem_be),
        .mem_rdata   (mem_rdata),
        .dec         (dec),
        .enc_data    (enc_data)
    );
endmodule

// File: rtl/ecc_rmw_chk.sv
module ecc_rmw_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ecc_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [31:0]       req_wdata,
    input logic [3:0]        req_be,
    input logic              scrub_ready,
    input logic              rsp_valid,
    input logic              rsp_corr,
    input logic              rsp_uncorr,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [3:0]        mem_be
);
    AST_FULL_WR_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write && req_be == 4'hF) |-> (mem_en && mem_we && mem_wdata == req_wdata)); // R1
    AST_WB_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !req_ready) |-> (mem_be == 4'hF)); // R2
    AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !req_ready) |-> (mem_addr == $past(mem_addr))); // R2
    AST_NO_WR_ON_UNCORR: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !req_ready) |=> (rsp_valid && !rsp_uncorr)); // R4
    AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !(req_write && (req_be == 4'hF || !ecc_en))) |=> !req_ready); // R8
    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready); // R8
    AST_SCRUB_YIELDS: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !scrub_ready); // R8
    AST_NO_READ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write && !ecc_en) |-> (mem_en && mem_we)); // R9
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_corr && rsp_uncorr)); // R10
    AST_FLAGS_NEED_RSP: assert property (@(posedge clk) disable iff (rst)
        (rsp_corr || rsp_uncorr) |-> rsp_valid); // R10
endmodule

bind ecc_rmw_unit ecc_rmw_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ecc_en      (ecc_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .req_be      (req_be),
    .scrub_ready (scrub_ready),
    .rsp_valid   (rsp_valid),
    .rsp_corr    (rsp_corr),
    .rsp_uncorr  (rsp_uncorr),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be)
);

// File: tb/sim_ecc_rmw_unit.sv
module sim_ecc_rmw_unit;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NV    = 13;
    localparam logic [5:0] NF = 6'd63;

    // {op[57:56], be[55:52], addr[51:44], data[43:12], flipA[11:6], flipB[5:0]}
    // op 0 read, 1 write, 2 scrub; flip 0..31 data bit, 32..38 check bit, 63 none
    localparam logic [57:0] VEC [NV] = '{
        {2'd1, 4'hF, 8'h10, 32'hDEADBEEF, NF,    NF   },
        {2'd0, 4'h0, 8'h10, 32'h0,        NF,    NF   },
        {2'd0, 4'h0, 8'h10, 32'h0,        6'd5,  NF   },
        {2'd2, 4'h0, 8'h10, 32'h0,        NF,    NF   },
        {2'd2, 4'h0, 8'h10, 32'h0,        NF,    NF   },
        {2'd1, 4'h1, 8'h10, 32'h000000AA, NF,    NF   },
        {2'd1, 4'hC, 8'h10, 32'h12340000, 6'd35, NF   },
        {2'd1, 4'h3, 8'h10, 32'h00005555, 6'd0,  6'd9 },
        {2'd0, 4'h0, 8'h10, 32'h0,        NF,    NF   },
        {2'd1, 4'hF, 8'h10, 32'h0F0F1234, NF,    NF   },
        {2'd0, 4'h0, 8'h10, 32'h0,        6'd38, NF   },
        {2'd2, 4'h0, 8'h10, 32'h0,        6'd31, NF   },
        {2'd1, 4'h4, 8'h3F, 32'h00770000, 6'd20, NF   }
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ecc_en = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, scrub_valid = 1'b0;
    logic [AW-1:0] req_addr = '0, scrub_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    req_be = '0;
    logic          req_ready, scrub_ready, rsp_valid, rsp_corr, rsp_uncorr;
    logic [31:0]   rsp_rdata;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [6:0]    mem_wchk, mem_rchk;
    logic [3:0]    mem_be;

    logic [31:0] mdat [DEPTH];
    logic [6:0]  mchk [DEPTH];
    logic [31:0] gold [DEPTH];
    int wr_cnt = 0, rd_cnt = 0;
    int n_chk = 0, n_fail = 0;

    logic [31:0] cap_data;
    logic        cap_corr, cap_unc, cap_rdy;
    int          cap_lat;

    always #5 clk = ~clk;

    ecc_rmw_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .ecc_en(ecc_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .scrub_valid(scrub_valid), .scrub_addr(scrub_addr), .scrub_ready(scrub_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_corr(rsp_corr), .rsp_uncorr(rsp_uncorr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wchk(mem_wchk), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_rchk(mem_rchk)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mdat[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
                if (mem_be == 4'hF) mchk[mem_addr] <= mem_wchk;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mdat[mem_addr];
                mem_rchk  <= mchk[mem_addr];
                rd_cnt    <= rd_cnt + 1;
            end
        end
    end

    function automatic logic [6:0] b_enc(input logic [31:0] d);
        logic [38:1] cw;
        logic [6:0]  c;
        int          k;
        cw = '0;
        k  = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k = k + 1;
            end
        end
        c = '0;
        for (int i = 0; i < 6; i++)
            for (int p = 1; p <= 38; p++)
                if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
        c[6] = (^d) ^ (^c[5:0]);
        return c;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic inject(input logic [7:0] a, input logic [5:0] idx);
        if (idx < 6'd32)      mdat[a][idx[4:0]] = ~mdat[a][idx[4:0]];
        else if (idx < 6'd39) mchk[a][idx - 6'd32] = ~mchk[a][idx - 6'd32];
    endtask

    task automatic run_op(input int op, input logic [3:0] be, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (op == 2) begin
            scrub_valid = 1'b1;
            scrub_addr  = a;
        end else begin
            req_valid = 1'b1;
            req_write = (op == 1);
            req_be    = be;
            req_addr  = a;
            req_wdata = d;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid   = 1'b0;
        scrub_valid = 1'b0;
        cap_rdy     = req_ready;
        cap_lat     = 1;
        while (!rsp_valid && cap_lat < 10) begin
            @(negedge clk);
            cap_lat = cap_lat + 1;
        end
        cap_data = rsp_rdata;
        cap_corr = rsp_corr;
        cap_unc  = rsp_uncorr;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog R10 actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mdat[i] = '0;
            mchk[i] = '0;
            gold[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R11: reset state
        check(req_ready == 1'b1, "R11 ready in reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R11 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(mem_en == 1'b0 && req_ready == 1'b1, "R11 idle after reset", 64'({mem_en, req_ready}), 64'd1);

        // table walk with protection on
        for (int v = 0; v < NV; v++) begin
            int          op, nerr, w0, r0, exp_lat;
            logic [3:0]  be;
            logic [7:0]  a;
            logic [31:0] d, mrg;
            logic [38:0] stored;
            op = int'(VEC[v][57:56]);
            be = VEC[v][55:52];
            a  = VEC[v][51:44];
            d  = VEC[v][43:12];
            inject(a, VEC[v][11:6]);
            inject(a, VEC[v][5:0]);
            stored = {mchk[a], mdat[a]};
            nerr   = $countones(stored ^ {b_enc(gold[a]), gold[a]});
            for (int b = 0; b < 4; b++) mrg[8*b +: 8] = be[b] ? d[8*b +: 8] : gold[a][8*b +: 8];
            w0 = wr_cnt;
            r0 = rd_cnt;
            run_op(op, be, a, d);
            exp_lat = (op == 1 && be == 4'hF) ? 1 : 2;
            check(cap_lat == exp_lat, "R5 latency", 64'(cap_lat), 64'(exp_lat));
            check(cap_rdy == (exp_lat == 1), "R8 busy window", 64'(cap_rdy), 64'(exp_lat == 1));
            check(cap_corr == (nerr == 1) && cap_unc == (nerr == 2), "R10 flags",
                  64'({cap_corr, cap_unc}), 64'({nerr == 1, nerr == 2}));
            if (op == 0) begin
                if (nerr < 2) check(cap_data == gold[a], "R5 R6 read data", 64'(cap_data), 64'(gold[a]));
                check({mchk[a], mdat[a]} == stored, "R5 read leaves memory", 64'({mchk[a], mdat[a]}), 64'(stored));
            end else if (op == 1 && be == 4'hF) begin
                gold[a] = d;
                check({mchk[a], mdat[a]} == {b_enc(d), d}, "R1 full write", 64'({mchk[a], mdat[a]}), 64'({b_enc(d), d}));
                check(rd_cnt == r0, "R1 no read", 64'(rd_cnt - r0), 64'd0);
            end else if (op == 1) begin
                check(rd_cnt == r0 + 1, "R2 one read", 64'(rd_cnt - r0), 64'd1);
                if (nerr >= 2) begin
                    check({mchk[a], mdat[a]} == stored && wr_cnt == w0, "R4 aborted write",
                          64'({mchk[a], mdat[a]}), 64'(stored));
                    gold[a] = mdat[a];
                    mchk[a] = b_enc(mdat[a]);
                end else begin
                    gold[a] = mrg;
                    check({mchk[a], mdat[a]} == {b_enc(mrg), mrg}, "R2 R3 merged write-back",
                          64'({mchk[a], mdat[a]}), 64'({b_enc(mrg), mrg}));
                end
            end else begin
                if (nerr == 1)
                    check({mchk[a], mdat[a]} == {b_enc(gold[a]), gold[a]} && wr_cnt == w0 + 1, "R7 scrub repair",
                          64'({mchk[a], mdat[a]}), 64'({b_enc(gold[a]), gold[a]}));
                else
                    check(wr_cnt == w0, "R7 scrub no write", 64'(wr_cnt - w0), 64'd0);
            end
        end

        // R8: bus request beats a simultaneous scrub
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10;
        scrub_valid = 1'b1; scrub_addr = 8'h55;
        #1;
        check(scrub_ready == 1'b0, "R8 scrub_ready low", 64'(scrub_ready), 64'd0);
        check(mem_addr == 8'h10, "R8 bus address wins", 64'(mem_addr), 64'h10);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; scrub_valid = 1'b0;
        repeat (2) @(negedge clk);

        // R9: protection off
        ecc_en = 1'b0;
        begin
            int r0;
            logic [6:0] c0;
            r0 = rd_cnt;
            c0 = mchk[8'h20];
            run_op(1, 4'h2, 8'h20, 32'h0000AB00);
            check(rd_cnt == r0, "R9 no read on sub-word write", 64'(rd_cnt - r0), 64'd0);
            check(mdat[8'h20] == 32'h0000AB00 && mchk[8'h20] == c0, "R9 lane write",
                  64'({mchk[8'h20], mdat[8'h20]}), 64'({c0, 32'h0000AB00}));
            inject(8'h20, 6'd0);
            run_op(0, 4'h0, 8'h20, 32'h0);
            check(cap_data == 32'h0000AB01 && !cap_corr && !cap_unc, "R9 raw read",
                  64'({cap_corr, cap_unc, cap_data}), 64'h0000AB01);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule